// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block holds the receive and transmit interrupt state of two serial channels, A and B, and produces a shared interrupt request. For each channel it keeps a receive-available flag and two pairs of flags: receive and transmit pending, and receive and transmit in service. From these it builds a 6-bit pending register and an 8-bit interrupt vector. The vector value depends on which source was last presented and on the status-high/status-low mode.

The surrounding serial core reports events to the block as one-cycle pulses, one bit per channel (bit 0 is channel A, bit 1 is channel B). The events are a received character, a data-register read, a data-register write, the reset-transmit-pending command and the reset-in-service command. Enable bits and the break status are level inputs. The core's transmit buffer empties at once, so a data-register write clears transmit pending and sets it again in the same cycle.

When more than one event pulse is high for one channel in a cycle, only the highest-priority event is applied. Within one cycle, channel A's event is applied before channel B's.

Top module: `sio_irq_vector`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all flags. After it, `pend` is 0x00, `vector` is 0x00, `rx_ready` is 0 and `irq` is 0.
- R2: `irq` is high when either channel meets at least one of these conditions: its `tx_en` bit is set and transmit is pending; its receive mode is 01 or 10 and receive is pending; its `brk_en` bit and its `brk` bit are both set. Receive modes 00 and 11 never request an interrupt.
- R3: Bit layout of `pend`: bit 0 is B break, bit 1 is B transmit, bit 2 is B receive, bit 3 is A break, bit 4 is A transmit, bit 5 is A receive. A break bit is loaded each cycle with `brk & brk_en` of its channel. A transmit bit is set only while that channel's `tx_en` is set.
- R4: With `stat_hi` low, the vector codes are: no interrupt 0x06, A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00.
- R5: With `stat_hi` high, the vector codes are: no interrupt 0x60, A receive 0x30, B receive 0x20, A transmit 0x10, B transmit 0x00.
- R6: A received character sets `rx_ready`, receive pending and receive in service. It sets the receive bit in `pend` and loads the receive vector, whatever else is pending.
- R7: When transmit becomes pending while receive is in service on that channel, transmit is not marked in service. Its `pend` bit and the vector are left unchanged, but it still counts towards `irq`.
- R8: The reset-in-service command acts in one of two ways. If receive is in service, it clears receive in service and presents any pending transmit (transmit in service, `pend` bit, vector). Otherwise it clears transmit in service only, and `pend` and `vector` are unchanged.
- R9: A data-register write leaves transmit pending set. It is presented as a new transmit interrupt, subject to R7.
- R10: A data-register read clears `rx_ready`, receive pending, receive in service and the receive `pend` bit, and loads the no-interrupt vector. If transmit is still pending, transmit is then presented.
- R11: The reset-transmit-pending command clears transmit pending, transmit in service and the transmit `pend` bit, and loads the no-interrupt vector. If receive is still pending, receive is then presented again.
- R12: Per-channel priority is: received character, then data read, then data write, then reset-transmit-pending, then reset-in-service. Only one event is applied per channel per cycle. Channel A is applied before channel B, so B's vector update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_ev | input | 2 | Character received pulse per channel |
| data_rd | input | 2 | Data-register read pulse per channel |
| data_wr | input | 2 | Data-register write pulse per channel |
| clr_tx | input | 2 | Reset-transmit-pending command pulse |
| clr_ius | input | 2 | Reset-in-service command pulse |
| brk | input | 2 | Break status level per channel |
| tx_en | input | 2 | Transmit interrupt enable per channel |
| brk_en | input | 2 | Break interrupt enable per channel |
| rx_mode_a | input | 2 | Channel A receive interrupt mode |
| rx_mode_b | input | 2 | Channel B receive interrupt mode |
| stat_hi | input | 1 | Status-high vector mode select |
| irq | output | 1 | Shared interrupt request |
| pend | output | 6 | Interrupt pending register |
| vector | output | 8 | Status-modified interrupt vector |
| rx_ready | output | 2 | Receive character available per channel |

## Verification
The assertions check a set of properties on every cycle:
- the reset values;
- that `vector` only ever holds one of the legal codes;
- that a received character or a data read on channel A leaves `rx_ready` and the A receive bit in the stated state;
- that a pending receive bit in a valid receive mode always raises `irq`.

Some behaviours only show in the bench's ordered scenarios, checked against a reference model. These are the transmit hold-off under receive in-service, the re-presentation of a waiting transmit after reset-in-service or a data read, the status-high versus status-low code choice, and the same-cycle ordering between channels.

// File: rtl/sio_irq_vector.sv
module sio_irq_vector (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rx_ev,
  input  logic [1:0] data_rd,
  input  logic [1:0] data_wr,
  input  logic [1:0] clr_tx,
  input  logic [1:0] clr_ius,
  input  logic [1:0] brk,
  input  logic [1:0] tx_en,
  input  logic [1:0] brk_en,
  input  logic [1:0] rx_mode_a,
  input  logic [1:0] rx_mode_b,
  input  logic       stat_hi,
  output logic       irq,
  output logic [5:0] pend,
  output logic [7:0] vector,
  output logic [1:0] rx_ready
);

  logic [1:0] rxi_q, txi_q, rxs_q, txs_q, rav_q;
  logic [1:0] rxi_n, txi_n, rxs_n, txs_n, rav_n;
  logic [5:0] pend_q, pend_n;
  logic [7:0] vec_q, vec_n;

  wire [7:0] none_code = stat_hi ? 8'h60 : 8'h06;

  function automatic logic [7:0] rx_code(input int c, input logic hi);
    if (c == 0) return hi ? 8'h30 : 8'h0C;
    return hi ? 8'h20 : 8'h04;
  endfunction

  function automatic logic [7:0] tx_code(input int c, input logic hi);
    if (c == 0) return hi ? 8'h10 : 8'h08;
    return 8'h00;
  endfunction

  always_comb begin
    rxi_n = rxi_q; txi_n = txi_q; rxs_n = rxs_q; txs_n = txs_q; rav_n = rav_q;
    pend_n = pend_q; vec_n = vec_q;
    for (int c = 0; c < 2; c++) begin
      logic do_rx, do_tx;
      int   b;
      b = (c == 0) ? 3 : 0;
      do_rx = 1'b0;
      do_tx = 1'b0;
      if (rx_ev[c]) begin
        rav_n[c] = 1'b1;
        do_rx = 1'b1;
      end else if (data_rd[c]) begin
        rav_n[c] = 1'b0;
        rxi_n[c] = 1'b0;
        rxs_n[c] = 1'b0;
        pend_n[b+2] = 1'b0;
        vec_n = none_code;
        do_tx = txi_n[c];
      end else if (data_wr[c]) begin
        txi_n[c] = 1'b0;
        do_tx = 1'b1;
      end else if (clr_tx[c]) begin
        txi_n[c] = 1'b0;
        txs_n[c] = 1'b0;
        pend_n[b+1] = 1'b0;
        vec_n = none_code;
        do_rx = rxi_n[c];
      end else if (clr_ius[c]) begin
        if (rxs_n[c]) begin
          rxs_n[c] = 1'b0;
          do_tx = txi_n[c];
        end else begin
          txs_n[c] = 1'b0;
        end
      end
      if (do_rx) begin
        rxi_n[c] = 1'b1;
        rxs_n[c] = 1'b1;
        pend_n[b+2] = 1'b1;
        vec_n = rx_code(c, stat_hi);
      end
      if (do_tx) begin
        txi_n[c] = 1'b1;
        if (!rxs_n[c]) begin
          txs_n[c] = 1'b1;
          if (tx_en[c]) pend_n[b+1] = 1'b1;
          vec_n = tx_code(c, stat_hi);
        end
      end
      pend_n[b] = brk[c] & brk_en[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxi_q <= '0; txi_q <= '0; rxs_q <= '0; txs_q <= '0; rav_q <= '0;
      pend_q <= '0; vec_q <= '0;
    end else begin
      rxi_q <= rxi_n; txi_q <= txi_n; rxs_q <= rxs_n; txs_q <= txs_n;
      rav_q <= rav_n; pend_q <= pend_n; vec_q <= vec_n;
    end
  end

  wire rx_ok_a = (rx_mode_a == 2'b01) || (rx_mode_a == 2'b10);
  wire rx_ok_b = (rx_mode_b == 2'b01) || (rx_mode_b == 2'b10);

  assign irq = (tx_en[0] & txi_q[0]) | (rx_ok_a & rxi_q[0]) | (brk_en[0] & brk[0]) |
               (tx_en[1] & txi_q[1]) | (rx_ok_b & rxi_q[1]) | (brk_en[1] & brk[1]);
  assign pend     = pend_q;
  assign vector   = vec_q;
  assign rx_ready = rav_q;

endmodule

// File: rtl/sio_irq_vector_chk.sv
module sio_irq_vector_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] rx_ev,
  input logic [1:0] data_rd,
  input logic [1:0] rx_mode_a,
  input logic       irq,
  input logic [5:0] pend,
  input logic [7:0] vector,
  input logic [1:0] rx_ready
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pend == 6'h00 && vector == 8'h00 && rx_ready == 2'b00));

  // R4
  legal_vector_chk: assert property (@(posedge clk) disable iff (rst)
    vector inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

  // R6
  rx_arrival_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ev[0] |=> (rx_ready[0] && pend[5]));

  // R10
  rx_read_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd[0] && !rx_ev[0]) |=> (!rx_ready[0] && !pend[5]));

  // R2
  rx_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[5] && (rx_mode_a == 2'b01 || rx_mode_a == 2'b10)) |-> irq);

endmodule

bind sio_irq_vector sio_irq_vector_chk chk (.*);

// File: tb/tb_sio_irq_vector.sv
module tb_sio_irq_vector;
  logic clk = 0, rst = 1;
  logic [1:0] rx_ev = 0, data_rd = 0, data_wr = 0, clr_tx = 0, clr_ius = 0;
  logic [1:0] brk = 0, tx_en = 2'b11, brk_en = 0, rx_mode_a = 2'b01, rx_mode_b = 2'b01;
  logic stat_hi = 0;
  logic irq;
  logic [5:0] pend;
  logic [7:0] vector;
  logic [1:0] rx_ready;

  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sio_irq_vector dut (.*);

  logic [1:0] m_ri, m_ti, m_rs, m_ts, m_ra;
  logic [5:0] m_p;
  logic [7:0] m_v;

  function automatic logic [7:0] code_none(); return stat_hi ? 8'h60 : 8'h06; endfunction
  function automatic logic [7:0] code_rx(int c);
    return c == 0 ? (stat_hi ? 8'h30 : 8'h0C) : (stat_hi ? 8'h20 : 8'h04);
  endfunction
  function automatic logic [7:0] code_tx(int c);
    return c == 0 ? (stat_hi ? 8'h10 : 8'h08) : 8'h00;
  endfunction
  function automatic int bit_rx(int c); return c == 0 ? 5 : 2; endfunction
  function automatic int bit_tx(int c); return c == 0 ? 4 : 1; endfunction

  task automatic present_rx(int c);
    m_ri[c] = 1; m_rs[c] = 1; m_p[bit_rx(c)] = 1; m_v = code_rx(c);
  endtask
  task automatic present_tx(int c);
    m_ti[c] = 1;
    if (!m_rs[c]) begin
      m_ts[c] = 1;
      if (tx_en[c]) m_p[bit_tx(c)] = 1;
      m_v = code_tx(c);
    end
  endtask

  task automatic model_clock();
    if (rst) begin
      m_ri = 0; m_ti = 0; m_rs = 0; m_ts = 0; m_ra = 0; m_p = 0; m_v = 0;
      return;
    end
    for (int c = 0; c < 2; c++) begin
      if (rx_ev[c]) begin m_ra[c] = 1; present_rx(c); end
      else if (data_rd[c]) begin
        m_ra[c] = 0; m_ri[c] = 0; m_rs[c] = 0; m_p[bit_rx(c)] = 0; m_v = code_none();
        if (m_ti[c]) present_tx(c);
      end
      else if (data_wr[c]) present_tx(c);
      else if (clr_tx[c]) begin
        m_ti[c] = 0; m_ts[c] = 0; m_p[bit_tx(c)] = 0; m_v = code_none();
        if (m_ri[c]) present_rx(c);
      end
      else if (clr_ius[c]) begin
        if (m_rs[c]) begin m_rs[c] = 0; if (m_ti[c]) present_tx(c); end
        else m_ts[c] = 0;
      end
      m_p[c == 0 ? 3 : 0] = brk[c] & brk_en[c];
    end
  endtask

  function automatic logic model_irq();
    logic r = 0;
    r |= tx_en[0] & m_ti[0];
    r |= (rx_mode_a == 2'b01 || rx_mode_a == 2'b10) & m_ri[0];
    r |= (rx_mode_b == 2'b01 || rx_mode_b == 2'b10) & m_ri[1];
    r |= tx_en[1] & m_ti[1];
    r |= |(brk & brk_en);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic compare_model(string req);
    chk(req, {31'b0, irq}, {31'b0, model_irq()});
    chk(req, {26'b0, pend}, {26'b0, m_p});
    chk(req, {24'b0, vector}, {24'b0, m_v});
    chk(req, {30'b0, rx_ready}, {30'b0, m_ra});
  endtask

  task automatic step();
    @(posedge clk);
    model_clock();
    @(negedge clk);
    rx_ev = 0; data_rd = 0; data_wr = 0; clr_tx = 0; clr_ius = 0;
  endtask

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); step(); step();
    rst = 0;
    // R1 reset state
    chk("R1", {24'b0, vector}, 0); chk("R1", {26'b0, pend}, 0);
    chk("R1", {31'b0, irq}, 0); chk("R1", {30'b0, rx_ready}, 0);

    // R6 R4 receive on A, low mode
    rx_ev = 2'b01; step();
    chk("R6", {26'b0, pend}, 6'h20); chk("R4", {24'b0, vector}, 8'h0C);
    chk("R6", {30'b0, rx_ready}, 2'b01); chk("R2", {31'b0, irq}, 1);
    // R7 R9 write while receive in service
    data_wr = 2'b01; step();
    chk("R7", {26'b0, pend}, 6'h20); chk("R7", {24'b0, vector}, 8'h0C);
    // R8 reset in service presents waiting transmit
    clr_ius = 2'b01; step();
    chk("R8", {26'b0, pend}, 6'h30); chk("R8", {24'b0, vector}, 8'h08);
    // R10 read with transmit still pending
    data_rd = 2'b01; step();
    chk("R10", {26'b0, pend}, 6'h10); chk("R10", {24'b0, vector}, 8'h08);
    chk("R10", {30'b0, rx_ready}, 0);
    // R11 reset transmit pending
    clr_tx = 2'b01; step();
    chk("R11", {26'b0, pend}, 0); chk("R11", {24'b0, vector}, 8'h06);
    chk("R11", {31'b0, irq}, 0);
    // R5 high mode receive on B
    stat_hi = 1; rx_ev = 2'b10; step();
    chk("R5", {26'b0, pend}, 6'h04); chk("R5", {24'b0, vector}, 8'h20);
    clr_ius = 2'b10; step();
    clr_ius = 2'b10; step();
    chk("R8", {26'b0, pend}, 6'h04); chk("R8", {24'b0, vector}, 8'h20);
    // R2 receive mode gating
    rx_mode_b = 2'b11; #1;
    chk("R2", {31'b0, irq}, 0);
    rx_mode_b = 2'b10; #1;
    chk("R2", {31'b0, irq}, 1);
    data_rd = 2'b10; step();
    chk("R5", {24'b0, vector}, 8'h60);
    // R12 both channels in one cycle, priority within channel
    data_wr = 2'b11; clr_tx = 2'b01; step();
    chk("R12", {26'b0, pend}, 6'h12); chk("R12", {24'b0, vector}, 8'h00);
    // R3 break bit
    brk = 2'b01; brk_en = 2'b01; step();
    chk("R3", {26'b0, pend}, 6'h1A);
    brk = 0; brk_en = 0;
    compare_model("R12");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        tx_en = 2'($urandom); brk_en = 2'($urandom); brk = 2'($urandom);
        rx_mode_a = 2'($urandom); rx_mode_b = 2'($urandom); stat_hi = 1'($urandom);
      end
      for (int c = 0; c < 2; c++) begin
        int k = $urandom_range(0, 7);
        case (k)
          0: rx_ev[c] = 1;
          1: data_rd[c] = 1;
          2: data_wr[c] = 1;
          3: clr_tx[c] = 1;
          4: clr_ius[c] = 1;
          5: begin data_wr[c] = 1; clr_ius[c] = 1; end
          default: ;
        endcase
      end
      step();
      compare_model("R12");
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule